// File: doc/BRIEF.md
# Funnel Shifter Unit

This block shifts or rotates a 32-bit word by any amount from 0 to 31 using a single right-extracting funnel. A 64-bit value is formed from an upper word and a lower word, and a 32-bit window is taken from it at a chosen right offset. Every operation reuses that one datapath. Only the upper word, the lower word and the offset are chosen per operation: zeros or sign copies above the operand for right shifts, the operand twice for rotation, and the operand above zeros for left shifts, with the offset negated modulo 32.

The shift count comes from one of two places: a 5-bit immediate field or a full-width register value. For a register value, only the low five bits count. The funnel is five cascaded levels of 2:1 multiplexers, and level k moves the window by 2^k. The result is captured in an output register, so it appears one clock after the inputs are presented.

Top module: `fsh_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` becomes zero on that edge. Otherwise `result` takes, on each rising edge, the value computed from the inputs present just before that edge.
- R2: With `op` = 2'b00 (logical left), `result` equals `operand` shifted left by the amount, with zeros entering at bit 0.
- R3: With `op` = 2'b01 (logical right), `result` equals `operand` shifted right by the amount, with zeros entering at bit 31.
- R4: With `op` = 2'b10 (arithmetic right), `result` equals `operand` shifted right by the amount, with copies of `operand[31]` entering at the top.
- R5: With `op` = 2'b11 (rotate right), bits leaving at bit 0 re-enter at bit 31, so `result` = `operand` rotated right by the amount.
- R6: With an effective amount of 0, `result` equals `operand` unchanged for all four operations, logical left included.
- R7: With `use_reg_amt` = 0, the amount is `imm_amt` and `reg_amt` has no effect. With `use_reg_amt` = 1, the amount is `reg_amt[4:0]` and `imm_amt` has no effect.
- R8: Bits `reg_amt[31:5]` never affect `result`, so register amounts of 32 or more act as their value modulo 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| operand | input | 32 | Word to shift or rotate |
| op | input | 2 | Operation: 00 left, 01 right logical, 10 right arithmetic, 11 rotate right |
| use_reg_amt | input | 1 | 1 selects `reg_amt` as the amount source, 0 selects `imm_amt` |
| imm_amt | input | 5 | Immediate shift amount |
| reg_amt | input | 32 | Register shift amount; only the low 5 bits are used |
| result | output | 32 | Registered shift or rotate result |

## Verification
The only internal state is the output register, so a fault in the operand chooser, the offset negation or any funnel level shows up as a wrong `result` on the edge right after the faulty inputs. A stuck level k corrupts exactly the amounts that have bit k set, so sweeping all 32 amounts for each operation isolates every level. A dropped sign fill, a missing zero-amount fix for left shifts, or a leak from the upper amount bits each differs from the arithmetic reference within that same cycle.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  typedef enum logic [1:0] {
    SH_SLL = 2'b00,
    SH_SRL = 2'b01,
    SH_SRA = 2'b10,
    SH_ROR = 2'b11
  } shift_op_e;
endpackage

// File: rtl/fsh_amount_sel.sv
module fsh_amount_sel #(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic             use_reg_amt,
  input  logic [AMT_W-1:0] imm_amt,
  input  logic [WIDTH-1:0] reg_amt,
  output logic [AMT_W-1:0] amt
);
  logic unused_amt_hi;
  assign unused_amt_hi = ^reg_amt[WIDTH-1:AMT_W];

  always_comb begin
    if (use_reg_amt) amt = reg_amt[AMT_W-1:0];
    else             amt = imm_amt;
  end
endmodule

// File: rtl/fsh_operand_sel.sv
module fsh_operand_sel
  import fsh_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand,
  input  shift_op_e        op,
  input  logic [AMT_W-1:0] amt,
  output logic [WIDTH-1:0] hi_word,
  output logic [WIDTH-1:0] lo_word,
  output logic [AMT_W-1:0] offset
);
  logic [AMT_W-1:0] neg_amt;
  assign neg_amt = -amt;

  always_comb begin
    hi_word = '0;
    lo_word = operand;
    offset  = amt;
    unique case (op)
      SH_SLL: begin
        hi_word = operand;
        // a zero count reads the low word directly, so keep the operand there
        lo_word = (amt == '0) ? operand : '0;
        offset  = neg_amt;
      end
      SH_SRL: hi_word = '0;
      SH_SRA: hi_word = {WIDTH{operand[WIDTH-1]}};
      SH_ROR: hi_word = operand;
      default: hi_word = '0;
    endcase
  end
endmodule

// File: rtl/fsh_extract.sv
module fsh_extract #(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH),
  localparam int FUNNEL_W = 2 * WIDTH
) (
  input  logic [WIDTH-1:0] hi_word,
  input  logic [WIDTH-1:0] lo_word,
  input  logic [AMT_W-1:0] offset,
  output logic [WIDTH-1:0] window
);
  logic [FUNNEL_W-1:0] level [0:AMT_W];

  assign level[0] = {hi_word, lo_word};

  for (genvar k = 0; k < AMT_W; k++) begin : g_level
    localparam int STEP = 1 << k;
    assign level[k+1] = offset[k] ? (level[k] >> STEP) : level[k];
  end

  assign window = level[AMT_W][WIDTH-1:0];
endmodule

// File: rtl/fsh_unit.sv
module fsh_unit
  import fsh_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] operand,
  input  logic [1:0]       op,
  input  logic             use_reg_amt,
  input  logic [AMT_W-1:0] imm_amt,
  input  logic [WIDTH-1:0] reg_amt,
  output logic [WIDTH-1:0] result
);
  logic [AMT_W-1:0] amt;
  logic [WIDTH-1:0] hi_word;
  logic [WIDTH-1:0] lo_word;
  logic [AMT_W-1:0] offset;
  logic [WIDTH-1:0] window;
  shift_op_e        op_e;

  assign op_e = shift_op_e'(op);

  fsh_amount_sel #(.WIDTH(WIDTH)) u_amt (
    .use_reg_amt (use_reg_amt),
    .imm_amt     (imm_amt),
    .reg_amt     (reg_amt),
    .amt         (amt)
  );

  fsh_operand_sel #(.WIDTH(WIDTH)) u_opsel (
    .operand (operand),
    .op      (op_e),
    .amt     (amt),
    .hi_word (hi_word),
    .lo_word (lo_word),
    .offset  (offset)
  );

  fsh_extract #(.WIDTH(WIDTH)) u_funnel (
    .hi_word (hi_word),
    .lo_word (lo_word),
    .offset  (offset),
    .window  (window)
  );

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= window;
  end
endmodule

// File: rtl/fsh_unit_chk.sv
module fsh_unit_chk #(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] operand,
  input logic [1:0]       op,
  input logic             use_reg_amt,
  input logic [AMT_W-1:0] imm_amt,
  input logic [WIDTH-1:0] reg_amt,
  input logic [WIDTH-1:0] result
);
  logic [AMT_W-1:0] eff_amt;
  assign eff_amt = use_reg_amt ? reg_amt[AMT_W-1:0] : imm_amt;

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (result == '0));

  p_left_zero_lsb_r2: assert property (@(posedge clk) disable iff (rst)
    (op == 2'b00 && eff_amt != '0) |=> (result[0] == 1'b0));

  p_right_zero_msb_r3: assert property (@(posedge clk) disable iff (rst)
    (op == 2'b01 && eff_amt != '0) |=> (result[WIDTH-1] == 1'b0));

  p_sign_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (op == 2'b10) |=> (result[WIDTH-1] == $past(operand[WIDTH-1])));

  p_rotate_ones_r5: assert property (@(posedge clk) disable iff (rst)
    (op == 2'b11) |=> ($countones(result) == $countones($past(operand))));

  p_zero_amount_r6: assert property (@(posedge clk) disable iff (rst)
    (eff_amt == '0) |=> (result == $past(operand)));
endmodule

bind fsh_unit fsh_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .operand     (operand),
  .op          (op),
  .use_reg_amt (use_reg_amt),
  .imm_amt     (imm_amt),
  .reg_amt     (reg_amt),
  .result      (result)
);

// File: tb/fsh_unit_tb.sv
module fsh_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  operand = '0;
  logic [1:0]    op = 2'b00;
  logic          use_reg_amt = 1'b0;
  logic [4:0]    imm_amt = '0;
  logic [W-1:0]  reg_amt = '0;
  logic [W-1:0]  result;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsh_unit #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .operand(operand), .op(op),
    .use_reg_amt(use_reg_amt), .imm_amt(imm_amt), .reg_amt(reg_amt),
    .result(result)
  );

  function automatic logic [W-1:0] model(input logic [1:0] o, input logic [W-1:0] a, input logic [4:0] s);
    logic [2*W-1:0] dbl;
    case (o)
      2'b00:   model = a << s;
      2'b01:   model = a >> s;
      2'b10:   model = $unsigned($signed(a) >>> s);
      default: begin dbl = {a, a} >> s; model = dbl[W-1:0]; end
    endcase
  endfunction

  task automatic check(input logic [W-1:0] exp, input string tag);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s op=%0d act=%h exp=%h", tag, op, result, exp);
    end
  endtask

  // drive on falling edge, result registered at next rising edge, sample on following falling edge
  task automatic run(input logic [1:0] o, input logic [W-1:0] a, input logic ur,
                     input logic [4:0] imm, input logic [W-1:0] rv,
                     input logic [W-1:0] exp, input string tag);
    op = o; operand = a; use_reg_amt = ur; imm_amt = imm; reg_amt = rv;
    @(posedge clk);
    @(negedge clk);
    check(exp, tag);
  endtask

  function automatic string op_tag(input logic [1:0] o);
    case (o)
      2'b00:   op_tag = "R2";
      2'b01:   op_tag = "R3";
      2'b10:   op_tag = "R4";
      default: op_tag = "R5";
    endcase
  endfunction

  initial begin
    logic [W-1:0] pats [8];
    pats[0] = 32'h8000_0001; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h1234_5678;
    pats[3] = 32'hDEAD_BEEF; pats[4] = 32'h0000_0000; pats[5] = 32'h7FFF_FFFE;
    pats[6] = $urandom;      pats[7] = $urandom | 32'h8000_0000;

    operand = 32'hA5A5_A5A5;
    repeat (2) @(negedge clk);
    check('0, "R1 reset");
    rst = 1'b0;

    for (int o = 0; o < 4; o++) begin
      for (int s = 0; s < 32; s++) begin
        for (int p = 0; p < 8; p++) begin
          logic [W-1:0] junk;
          junk = $urandom;
          if (s == 0)
            run(2'(o), pats[p], 1'b0, 5'(s), junk, pats[p], "R6 zero amount");
          else
            run(2'(o), pats[p], 1'b0, 5'(s), junk, model(2'(o), pats[p], 5'(s)), op_tag(2'(o)));
        end
      end
    end

    // R7: register source, immediate is a distractor
    for (int o = 0; o < 4; o++) begin
      for (int s = 0; s < 32; s++) begin
        logic [W-1:0] a;
        a = $urandom;
        run(2'(o), a, 1'b1, 5'(31 - s), 32'(s), model(2'(o), a, 5'(s)), "R7 reg source");
      end
    end

    // R8: upper register bits ignored
    for (int o = 0; o < 4; o++) begin
      for (int s = 0; s < 32; s++) begin
        logic [W-1:0] a;
        logic [W-1:0] hi_junk;
        a = $urandom;
        hi_junk = $urandom;
        run(2'(o), a, 1'b1, 5'd0, {hi_junk[W-1:5], 5'(s)}, model(2'(o), a, 5'(s)), "R8 high amount bits");
      end
      run(2'(o), 32'hC0DE_F00D, 1'b1, 5'd3, 32'd32, 32'hC0DE_F00D, "R8 amount 32");
    end

    // R1: reset mid-run clears a non-zero result
    run(2'b11, 32'hFFFF_0000, 1'b0, 5'd4, '0, 32'h0FFF_F000, "R5");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check('0, "R1 reset mid-run");
    rst = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1 act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule